// File: doc/BRIEF.md
# Line-Aligned Access Splitter

This block takes one memory access and cuts it into pieces that never cross a cache-line boundary. The access is given as a base byte address, a byte count and a per-byte enable mask. The block walks the access from the lowest address upward and offers one fragment at a time on a valid/ready output. Each fragment carries its start address and its byte count. An unaligned access becomes a short leading piece, then zero or more whole-line pieces, then a short trailing piece when the end address is not line aligned. An access that fits inside one line leaves as a single fragment.

A fragment in which every byte enable is clear is not offered downstream. It is counted as skipped instead. When the walk is over, the block raises `done` for one cycle and shows how many fragments were emitted and how many were skipped. A separate flag marks the case where nothing was emitted at all. The line width is a power-of-two parameter. A new access is taken only once the previous one has fully drained.

Top module: `frag_splitter`

## Requirements
- R1: After reset, `in_ready` is 1, `frag_valid` is 0 and `done` is 0.
- R2: An access whose bytes all lie in one line produces exactly one fragment, with `frag_addr` equal to the base address and `frag_size` equal to the access size. This includes a line-aligned access of exactly `LINE_BYTES` bytes.
- R3: When an access crosses a line boundary, its first fragment starts at the base address and is `LINE_BYTES` minus the base address's offset within its line bytes long.
- R4: Fragments are offered in ascending address order and each starts where the previous one ended. Every fragment between the first and the last is exactly `LINE_BYTES` long and line aligned.
- R5: The last fragment ends exactly at base plus size. If that end address is line aligned, there is no short trailing fragment.
- R6: Bit k of `in_be` enables byte `in_addr + k`. A fragment whose covered enable bits are all 0 is never offered on the output, but it is counted in `skipped`.
- R7: If every fragment of an access is disabled, `frag_valid` stays 0 for the whole access. `done` then rises with `all_disabled` = 1 and `emitted` = 0.
- R8: `done` is high for exactly one cycle, after the last fragment has been handed off or skipped. While `done` is high, `emitted` and `skipped` hold the counts for that access. `all_disabled` is 0 whenever at least one fragment was emitted.
- R9: `in_ready` is 0 from the cycle after an access is accepted until after `done`. Any `in_valid` raised in that window is ignored and does not change the fragments being produced.
- R10: While `frag_valid` is 1 and `frag_ready` is 0, the same fragment stays offered with unchanged `frag_addr` and `frag_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An access is presented |
| in_ready | output | 1 | The block is idle and takes the access |
| in_addr | input | ADDR_W | Base byte address of the access |
| in_size | input | SIZE_W | Access length in bytes, 1 to MAX_BYTES |
| in_be | input | MAX_BYTES | Byte enables; bit k covers byte in_addr+k |
| frag_valid | output | 1 | A fragment is offered |
| frag_ready | input | 1 | Downstream takes the fragment |
| frag_addr | output | ADDR_W | Start address of the fragment |
| frag_size | output | FSIZE_W | Fragment length in bytes |
| done | output | 1 | One-cycle pulse when the access has been walked |
| all_disabled | output | 1 | With done: no fragment was emitted |
| emitted | output | CNT_W | Fragments handed off for this access |
| skipped | output | CNT_W | Fragments dropped as fully disabled |

## Verification
The bench targets the edges of the size arithmetic. These cases include an access that exactly fills one aligned line, an end address landing on a boundary, a one-byte tail, and a maximum-length access starting one byte past a line start. A design with an off-by-one in the room computation would emit an extra zero-length or over-long piece at one of these points. A skipped fragment in the middle checks that the enable window moves with the address. A window that stayed put would test the wrong bits and drop or emit the wrong fragment. Back-pressure and a held `in_valid` during a walk expose a block that advances without a handshake or reloads mid-access. The all-disabled access checks that nothing leaks out and that the flag and counts agree.

// File: rtl/frag_pkg.sv
package frag_pkg;

  // Walk controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } frag_state_t;

endpackage

// File: rtl/frag_geom.sv
// Size of the current piece: the smaller of the room left in the line
// and the bytes left in the access.
module frag_geom #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SIZE_W     = 7,
  localparam int LINE_LOG  = $clog2(LINE_BYTES),
  localparam int FSIZE_W   = $clog2(LINE_BYTES + 1)
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [SIZE_W-1:0]  rem_bytes,
  output logic [FSIZE_W-1:0] piece_size,
  output logic               piece_last
);

  localparam int CW = (SIZE_W > FSIZE_W) ? SIZE_W : FSIZE_W;

  logic [LINE_LOG-1:0] line_off;
  logic [FSIZE_W-1:0]  room;
  logic [CW-1:0]       rem_x;
  logic [CW-1:0]       room_x;

  always_comb begin
    line_off   = cur_addr[LINE_LOG-1:0];
    room       = FSIZE_W'(LINE_BYTES) - FSIZE_W'(line_off);
    rem_x      = CW'(rem_bytes);
    room_x     = CW'(room);
    piece_last = (rem_x <= room_x);
    piece_size = piece_last ? FSIZE_W'(rem_bytes) : room;
  end

endmodule

// File: rtl/frag_mask.sv
// Tells whether any byte of the current piece is enabled.
module frag_mask #(
  parameter int LINE_BYTES = 16,
  localparam int FSIZE_W   = $clog2(LINE_BYTES + 1)
) (
  input  logic [LINE_BYTES-1:0] be_window,
  input  logic [FSIZE_W-1:0]    piece_size,
  output logic                  piece_any
);

  logic [LINE_BYTES-1:0] keep;

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    assign keep[i] = be_window[i] && (FSIZE_W'(i) < piece_size);
  end

  assign piece_any = |keep;

endmodule

// File: rtl/frag_tally.sv
// Emitted and skipped fragment counters for one access.
module frag_tally #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc_emit,
  input  logic             inc_skip,
  output logic [CNT_W-1:0] emitted,
  output logic [CNT_W-1:0] skipped
);

  logic [CNT_W-1:0] emit_d, skip_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear || inc_emit || inc_skip;
    emit_d = emitted;
    skip_d = skipped;
    if (clear) begin
      emit_d = '0;
      skip_d = '0;
    end else begin
      if (inc_emit) emit_d = emitted + CNT_W'(1);
      if (inc_skip) skip_d = skipped + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emitted <= '0;
      skipped <= '0;
    end else if (cnt_en) begin
      emitted <= emit_d;
      skipped <= skip_d;
    end
  end

endmodule

// File: rtl/frag_splitter.sv
// Splits one access into line-bounded fragments, lowest address first.
// rst_n is asserted asynchronously and must be released synchronously
// by the reset tree. LINE_BYTES must be a power of two, at least 2 and
// no larger than MAX_BYTES.
module frag_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 64,
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1),
  localparam int FSIZE_W   = $clog2(LINE_BYTES + 1),
  localparam int MAX_FRAGS = MAX_BYTES / LINE_BYTES + 2,
  localparam int CNT_W     = $clog2(MAX_FRAGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [SIZE_W-1:0]    in_size,
  input  logic [MAX_BYTES-1:0] in_be,
  output logic                 frag_valid,
  input  logic                 frag_ready,
  output logic [ADDR_W-1:0]    frag_addr,
  output logic [FSIZE_W-1:0]   frag_size,
  output logic                 done,
  output logic                 all_disabled,
  output logic [CNT_W-1:0]     emitted,
  output logic [CNT_W-1:0]     skipped
);

  import frag_pkg::*;

  frag_state_t            state_q, state_d;
  logic [ADDR_W-1:0]      addr_q, addr_d;
  logic [SIZE_W-1:0]      rem_q, rem_d;
  logic [MAX_BYTES-1:0]   be_q, be_d;

  logic [FSIZE_W-1:0]     piece_size;
  logic                   piece_last;
  logic                   piece_any;
  logic                   accept;
  logic                   step;
  logic                   walk_en;

  frag_geom #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .SIZE_W    (SIZE_W)
  ) u_geom (
    .cur_addr  (addr_q),
    .rem_bytes (rem_q),
    .piece_size(piece_size),
    .piece_last(piece_last)
  );

  frag_mask #(
    .LINE_BYTES(LINE_BYTES)
  ) u_mask (
    .be_window (be_q[LINE_BYTES-1:0]),
    .piece_size(piece_size),
    .piece_any (piece_any)
  );

  frag_tally #(
    .CNT_W(CNT_W)
  ) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .inc_emit(step && piece_any),
    .inc_skip(step && !piece_any),
    .emitted (emitted),
    .skipped (skipped)
  );

  // Handshake and step decode
  always_comb begin
    in_ready   = (state_q == ST_IDLE);
    accept     = in_ready && in_valid;
    frag_valid = (state_q == ST_WALK) && piece_any;
    step       = (state_q == ST_WALK) && (!piece_any || frag_ready);
    walk_en    = accept || step;
    frag_addr  = addr_q;
    frag_size  = piece_size;
    done       = (state_q == ST_DONE);
    all_disabled = done && (emitted == '0);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_WALK;
      ST_WALK: if (step && piece_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Walk registers: load on accept, advance one piece on each step
  always_comb begin
    if (accept) begin
      addr_d = in_addr;
      rem_d  = in_size;
      be_d   = in_be;
    end else begin
      addr_d = addr_q + ADDR_W'(piece_size);
      rem_d  = rem_q - SIZE_W'(piece_size);
      be_d   = be_q >> piece_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      be_q   <= '0;
    end else if (walk_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      be_q   <= be_d;
    end
  end

endmodule

// File: rtl/frag_splitter_chk.sv
module frag_splitter_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 3,
  localparam int LINE_LOG  = $clog2(LINE_BYTES),
  localparam int FSIZE_W   = $clog2(LINE_BYTES + 1),
  localparam int SPW       = FSIZE_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               frag_valid,
  input logic               frag_ready,
  input logic [ADDR_W-1:0]  frag_addr,
  input logic [FSIZE_W-1:0] frag_size,
  input logic               done,
  input logic               all_disabled,
  input logic [CNT_W-1:0]   emitted
);

  logic [SPW-1:0] span;
  assign span = SPW'(frag_addr[LINE_LOG-1:0]) + SPW'(frag_size);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr) && $stable(frag_size)));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!frag_valid && !in_ready));

  // R7
  all_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_disabled |-> (done && emitted == '0));

  // R4
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (frag_size != '0 && span <= SPW'(LINE_BYTES)));

endmodule

bind frag_splitter frag_splitter_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .frag_valid  (frag_valid),
  .frag_ready  (frag_ready),
  .frag_addr   (frag_addr),
  .frag_size   (frag_size),
  .done        (done),
  .all_disabled(all_disabled),
  .emitted     (emitted)
);

// File: tb/frag_splitter_bench.sv
`timescale 1ns/1ps
module frag_splitter_bench;

  localparam int ADDR_W  = 32;
  localparam int LINE    = 16;
  localparam int MAXB    = 64;
  localparam int SIZE_W  = $clog2(MAXB + 1);
  localparam int FSIZE_W = $clog2(LINE + 1);
  localparam int CNT_W   = $clog2(MAXB / LINE + 3);

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [ADDR_W-1:0]   in_addr;
  logic [SIZE_W-1:0]   in_size;
  logic [MAXB-1:0]     in_be;
  logic                frag_valid;
  logic                frag_ready;
  logic [ADDR_W-1:0]   frag_addr;
  logic [FSIZE_W-1:0]  frag_size;
  logic                done;
  logic                all_disabled;
  logic [CNT_W-1:0]    emitted;
  logic [CNT_W-1:0]    skipped;

  int n_checks = 0;
  int n_errors = 0;

  frag_splitter #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE),
    .MAX_BYTES (MAXB)
  ) u_frag_splitter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_be(in_be),
    .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_addr(frag_addr), .frag_size(frag_size),
    .done(done), .all_disabled(all_disabled),
    .emitted(emitted), .skipped(skipped)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [MAXB-1:0] ones(input int n);
    logic [MAXB-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Drives one access, collects fragments and compares with a model
  task automatic run_access(input longint a, input int sz, input logic [MAXB-1:0] be,
                            input int stall, input bit keep_valid, input string req);
    longint exp_a[16];
    int     exp_s[16];
    int     n_exp, n_skip, got, cyc;
    longint pos;
    int     rem, k, room, psz;
    bit     any, seen_done, held, busy_ok;
    longint h_a;
    int     h_s;
    n_exp = 0; n_skip = 0; pos = a; rem = sz; k = 0;
    while (rem > 0) begin
      room = LINE - int'(pos % LINE);
      psz  = (rem < room) ? rem : room;
      any  = 1'b0;
      for (int j = 0; j < psz; j++) if (be[k + j]) any = 1'b1;
      if (any) begin
        exp_a[n_exp] = pos & 64'hFFFF_FFFF;
        exp_s[n_exp] = psz;
        n_exp++;
      end else begin
        n_skip++;
      end
      pos += psz; rem -= psz; k += psz;
    end

    @(negedge clk);
    in_addr = ADDR_W'(a); in_size = SIZE_W'(sz); in_be = be; in_valid = 1'b1;
    check(in_ready == 1'b1, "R9", "in_ready idle", in_ready, 1);
    @(negedge clk);
    if (keep_valid) begin
      in_addr = ADDR_W'(a) ^ 32'h0000_0140;
      in_size = SIZE_W'(1);
      in_be   = ones(1);
    end else begin
      in_valid = 1'b0;
    end
    got = 0; cyc = 0; seen_done = 0; held = 0; busy_ok = 1; h_a = 0; h_s = 0;
    while (!seen_done && cyc < 300) begin
      if (done) begin
        seen_done = 1;
        in_valid  = 1'b0;
        frag_ready = 1'b0;
        check(got == n_exp, req, "fragments seen", got, n_exp);
        check(emitted == CNT_W'(n_exp), "R8", "emitted", emitted, n_exp);
        check(skipped == CNT_W'(n_skip), "R6", "skipped", skipped, n_skip);
        check(all_disabled == (n_exp == 0), "R7", "all_disabled", all_disabled, n_exp == 0);
      end else begin
        if (in_ready) busy_ok = 0;
        if (held) begin
          check(frag_valid && frag_addr == ADDR_W'(h_a) && frag_size == FSIZE_W'(h_s),
                "R10", "held fragment", frag_addr, h_a);
          held = 0;
        end
        if (frag_valid) begin
          frag_ready = (stall > 0) ? ((cyc % stall) != 0) : 1'b1;
          if (frag_ready) begin
            if (got < n_exp) begin
              check(frag_addr == ADDR_W'(exp_a[got]), req, "frag_addr", frag_addr, exp_a[got]);
              check(frag_size == FSIZE_W'(exp_s[got]), req, "frag_size", frag_size, exp_s[got]);
            end else begin
              check(1'b0, req, "extra fragment", frag_addr, 0);
            end
            got++;
          end else begin
            held = 1; h_a = frag_addr; h_s = frag_size;
          end
        end else begin
          frag_ready = 1'b0;
        end
      end
      @(negedge clk);
      cyc++;
    end
    check(seen_done, "R8", "done reached", seen_done, 1);
    check(done == 1'b0, "R8", "done single cycle", done, 0);
    check(busy_ok, "R9", "in_ready low while busy", busy_ok, 1);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(frag_valid == 1'b0, "R1", "frag_valid", frag_valid, 0);
    check(done == 1'b0, "R1", "done", done, 0);
  endtask

  task automatic t_single_line();
    run_access(32'h1004, 8, ones(8), 0, 0, "R2");
    run_access(32'h2000, 16, ones(16), 0, 0, "R2");
  endtask

  task automatic t_crossing();
    // 6 + 16 + 16 + 2
    run_access(32'h300A, 40, ones(40), 0, 0, "R3");
  endtask

  task automatic t_aligned_end();
    // 8 + 16, no tail
    run_access(32'h4008, 24, ones(24), 0, 0, "R5");
    // 15 + 16 + 16 + 16 + 1
    run_access(32'h6001, 64, ones(64), 0, 0, "R4");
  endtask

  task automatic t_skip_middle();
    logic [MAXB-1:0] m;
    m = ones(40);
    for (int i = 6; i < 22; i++) m[i] = 1'b0;
    run_access(32'h300A, 40, m, 0, 0, "R6");
  endtask

  task automatic t_all_off();
    run_access(32'h5003, 20, '0, 0, 0, "R7");
  endtask

  task automatic t_backpressure();
    run_access(32'h300A, 40, ones(40), 3, 0, "R10");
  endtask

  task automatic t_busy_input();
    run_access(32'h7007, 30, ones(30), 2, 1, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_size = '0; in_be = '0;
    frag_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_line();
    t_crossing();
    t_aligned_end();
    t_skip_middle();
    t_all_off();
    t_backpressure();
    t_busy_input();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule